// File: doc/BRIEF.md
# Flash Write-Control Register Sequencer

This block is the register front end for write operations on a flash array split into two modules, with the primary module divided into banks. Software uses a small register bus to load a data word, a target address and a command into the block. It then sets the start bit to launch a program, an erase or a protection-set operation. The block checks the command and hands it to the flash engine as a one-cycle start pulse, together with an operation code and a module select. While the operation runs, the block locks the register file and marks every bank as busy.

While the block is locked, reads of any register except the status word return a fixed invalid word and raise a trap indication, and writes have no effect. The one exception is the hold bit in the command register: writing it suspends the running operation, and clearing it resumes the operation. Each busy bit gates direct reads and writes to its bank. A protection-set command is accepted only when its target lies inside a fixed address window. When the engine finishes, it can only clear bits of the stored protection word. A rejected command sets a sticky sequence-error flag and leaves the banks free.

Top module: `flash_wr_seq`

## Requirements
- R1: After reset the status word (index 0) reads 0, the command word (index 1) reads 0x0000, the error word (index 5) reads 0, the protection word (index 6) reads 0xFFFF, and eng_start is low.
- R2: Writing index 1 with bit 15 (start) set and exactly one of bit 13 (program), bit 12 (erase) or bit 11 (protection-set) set is a valid command when the block is unlocked. On the next clock edge the block sets stat_lock and all stat_busy bits, and eng_start pulses for one cycle. eng_op is 1 for program, 2 for erase or 3 for protection-set, and eng_mod copies bit 8 (1 = primary module, 0 = secondary module).
- R3: While stat_lock is high, a read of any index other than 0 returns 0xFFFF with bus_trap high. Index 0 returns {busy, lock} in bits [2:0] without a trap.
- R4: While stat_lock is high, writes to the data (2), address-low (3), address-high (4) and error (5) registers have no effect.
- R5: A bank read (bank_rd) while that bank's busy bit is set raises bank_trap, and a bank write (bank_wr) to it does not raise bank_wr_en. When the bank is not busy, reads give no trap and writes pass through to bank_wr_en.
- R6: During an operation, writing index 1 with bit 14 (hold) set clears all busy bits on the next edge, keeps stat_lock high and raises eng_hold. Writing index 1 with bit 14 clear resumes: all busy bits set again and eng_hold drops. eng_done is ignored while the operation is held.
- R7: eng_done during a running operation clears stat_lock and all busy bits on the next edge. The command word, including the module-select bit 8 and the protection-set bit 11, then reads 0x0000.
- R8: For a protection-set command, the target address is {address-high[3:0], address-low[15:0]}. If it lies outside 0x0EDFB0..0x0EDFBF, the command is rejected. Error bit 0 is set, no busy bit is raised, eng_start stays low, and stat_lock is high for exactly one cycle.
- R9: When a protection-set operation completes, the protection word becomes its old value AND the data register, so stored 1s can only turn to 0s. Both window edges 0x0EDFB0 and 0x0EDFBF are accepted.
- R10: A start with zero or more than one operation bit set is rejected in the same way as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_idx | input | 3 | Register index |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| bus_trap | output | 1 | Invalid register access indication |
| bank_rd | input | 1 | Direct bank read request |
| bank_wr | input | 1 | Direct bank write request |
| bank_sel | input | 1 | Bank number of the request |
| bank_trap | output | 1 | Bank read returned invalid data |
| bank_wr_en | output | 1 | Bank write forwarded to the array |
| eng_start | output | 1 | One-cycle operation start pulse |
| eng_op | output | 2 | Operation code: 1 program, 2 erase, 3 protection-set |
| eng_mod | output | 1 | Module select: 1 primary, 0 secondary |
| eng_hold | output | 1 | Operation held (suspend) |
| eng_done | input | 1 | Operation finished pulse from the engine |
| stat_lock | output | 1 | Register file locked |
| stat_busy | output | 2 | Per-bank busy flags |

## Verification
The bench builds the block with its default parameters: two banks and the window 0x0EDFB0..0x0EDFBF. It uses an engine model that answers each start after four cycles. With two banks, a single select bit reaches both busy flags, and suspend and resume visibly clear and restore each of them. With the default window, the bench probes the addresses just below and just above the window as well as both window edges. A reference model in the bench replays every register write and engine pulse, and the bench compares lock, busy, start, operation code, module and hold with the model on every clock.

// File: rtl/fwc_pkg.sv
// Shared definitions for the flash write-control sequencer.
// Assumes a 16-bit register bus and a 3-bit register index.
package fwc_pkg;
    localparam int unsigned DW = 16;
    localparam int unsigned IW = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2,
        ST_REJ  = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PGM  = 2'd1,
        OP_ERS  = 2'd2,
        OP_SPR  = 2'd3
    } eng_op_e;

    localparam logic [IW-1:0] IDX_STAT = 3'd0;
    localparam logic [IW-1:0] IDX_CMD  = 3'd1;
    localparam logic [IW-1:0] IDX_DATA = 3'd2;
    localparam logic [IW-1:0] IDX_ALO  = 3'd3;
    localparam logic [IW-1:0] IDX_AHI  = 3'd4;
    localparam logic [IW-1:0] IDX_ERR  = 3'd5;
    localparam logic [IW-1:0] IDX_PROT = 3'd6;

    localparam int unsigned CB_GO   = 15;
    localparam int unsigned CB_HOLD = 14;
    localparam int unsigned CB_PGM  = 13;
    localparam int unsigned CB_ERS  = 12;
    localparam int unsigned CB_SPR  = 11;
    localparam int unsigned CB_MOD  = 8;
endpackage

// File: rtl/fwc_bank_gate.sv
// Per-bank access gate: blocks bank reads and writes while the bank is busy.
// Assumes bank_sel addresses one of N_BANK banks; out-of-range selects hit nothing.
module fwc_bank_gate #(
    parameter int unsigned N_BANK = 2,
    localparam int unsigned BSW = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
    input  logic [N_BANK-1:0] busy,
    input  logic              bank_rd,
    input  logic              bank_wr,
    input  logic [BSW-1:0]    bank_sel,
    output logic              bank_trap,
    output logic              bank_wr_en
);
    logic [N_BANK-1:0] trap_v;
    logic [N_BANK-1:0] pass_v;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        // Decode the request onto this bank and apply its busy flag.
        always_comb begin
            trap_v[b] = bank_rd && (bank_sel == BSW'(b)) && busy[b];
            pass_v[b] = bank_wr && (bank_sel == BSW'(b)) && !busy[b];
        end
    end

    // Merge the per-bank results.
    always_comb begin
        bank_trap  = |trap_v;
        bank_wr_en = |pass_v;
    end
endmodule

// File: rtl/fwc_regs.sv
// Data, address, error and protection registers, plus the read mux.
// Assumes the sequencer supplies lock, busy and the command word. Writes are
// accepted only while unlocked. Reads other than the status word are masked while locked.
module fwc_regs
    import fwc_pkg::*;
#(
    parameter int unsigned N_BANK   = 2,
    parameter int unsigned AW       = 20,
    parameter logic [DW-1:0] BAD_WORD = 16'hFFFF,
    localparam int unsigned AHW = AW - DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [IW-1:0]     bus_idx,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_trap,
    input  logic              lock,
    input  logic [N_BANK-1:0] busy,
    input  logic [DW-1:0]     cmd_word,
    input  logic              err_set,
    input  logic              prot_upd,
    output logic [AW-1:0]     tgt_addr
);
    logic [DW-1:0]  data_q;
    logic [DW-1:0]  alo_q;
    logic [AHW-1:0] ahi_q;
    logic           err_q;
    logic [DW-1:0]  prot_q;
    logic           wr_ok;

    // Software writes are only accepted while the register file is unlocked.
    always_comb wr_ok = bus_wr && !lock;

    // Register storage with lock gating, error set and protection update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            alo_q  <= '0;
            ahi_q  <= '0;
            err_q  <= 1'b0;
            prot_q <= '1;
        end else begin
            if (wr_ok && bus_idx == IDX_DATA) data_q <= bus_wdata;
            if (wr_ok && bus_idx == IDX_ALO)  alo_q  <= bus_wdata;
            if (wr_ok && bus_idx == IDX_AHI)  ahi_q  <= bus_wdata[AHW-1:0];
            if (err_set)                      err_q  <= 1'b1;
            else if (wr_ok && bus_idx == IDX_ERR) err_q <= bus_wdata[0];
            if (prot_upd)                     prot_q <= prot_q & data_q;
        end
    end

    // Full target address for the window check.
    always_comb tgt_addr = {ahi_q, alo_q};

    // Read mux: status always visible, everything else masked while locked.
    always_comb begin
        bus_trap  = 1'b0;
        bus_rdata = '0;
        if (bus_idx == IDX_STAT) begin
            bus_rdata = DW'({busy, lock});
        end else if (lock) begin
            bus_rdata = BAD_WORD;
            bus_trap  = bus_rd;
        end else begin
            case (bus_idx)
                IDX_CMD:  bus_rdata = cmd_word;
                IDX_DATA: bus_rdata = data_q;
                IDX_ALO:  bus_rdata = alo_q;
                IDX_AHI:  bus_rdata = DW'(ahi_q);
                IDX_ERR:  bus_rdata = DW'(err_q);
                IDX_PROT: bus_rdata = prot_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fwc_seq.sv
// Operation sequencer: validates a start command, drives lock/busy, launches the
// engine and follows hold/resume and completion. Assumes eng_done is a one-cycle
// pulse, which is honoured only while the operation is running (not held).
module fwc_seq
    import fwc_pkg::*;
#(
    parameter int unsigned N_BANK = 2,
    parameter int unsigned AW     = 20,
    parameter logic [AW-1:0] WIN_LO = 20'h0EDFB0,
    parameter logic [AW-1:0] WIN_HI = 20'h0EDFBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DW-1:0]     wdata,
    input  logic [AW-1:0]     tgt_addr,
    input  logic              eng_done,
    output logic              lock,
    output logic [N_BANK-1:0] busy,
    output logic [DW-1:0]     cmd_word,
    output logic              eng_start,
    output logic [1:0]        eng_op,
    output logic              eng_mod,
    output logic              eng_hold,
    output logic              err_set,
    output logic              prot_upd
);
    seq_st_e st_q;
    eng_op_e op_q;
    logic    go_req;
    logic    one_op;
    logic    in_win;
    logic    cmd_ok;
    eng_op_e op_dec;

    // Command decode and validation.
    always_comb begin
        go_req = cmd_wr && wdata[CB_GO] && (st_q == ST_IDLE);
        one_op = $onehot({wdata[CB_PGM], wdata[CB_ERS], wdata[CB_SPR]});
        in_win = (tgt_addr >= WIN_LO) && (tgt_addr <= WIN_HI);
        cmd_ok = one_op && (!wdata[CB_SPR] || in_win);
        if (wdata[CB_PGM])      op_dec = OP_PGM;
        else if (wdata[CB_ERS]) op_dec = OP_ERS;
        else                    op_dec = OP_SPR;
    end

    // Side effects that land in the register file on the same edge.
    always_comb begin
        err_set  = go_req && !cmd_ok;
        prot_upd = (st_q == ST_RUN) && eng_done && (op_q == OP_SPR);
    end

    // Sequencer state, lock, busy and engine interface.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            op_q      <= OP_NONE;
            lock      <= 1'b0;
            busy      <= '0;
            cmd_word  <= '0;
            eng_start <= 1'b0;
            eng_mod   <= 1'b0;
            eng_hold  <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (go_req) begin
                        lock     <= 1'b1;
                        cmd_word <= wdata & DW'((1 << CB_GO) | (1 << CB_PGM) | (1 << CB_ERS)
                                               | (1 << CB_SPR) | (1 << CB_MOD));
                        if (cmd_ok) begin
                            st_q      <= ST_RUN;
                            busy      <= '1;
                            eng_start <= 1'b1;
                            op_q      <= op_dec;
                            eng_mod   <= wdata[CB_MOD];
                        end else begin
                            st_q <= ST_REJ;
                        end
                    end else if (cmd_wr) begin
                        cmd_word <= wdata & DW'((1 << CB_PGM) | (1 << CB_ERS)
                                               | (1 << CB_SPR) | (1 << CB_MOD));
                    end
                end
                ST_RUN: begin
                    if (eng_done) begin
                        st_q     <= ST_IDLE;
                        lock     <= 1'b0;
                        busy     <= '0;
                        cmd_word <= '0;
                        op_q     <= OP_NONE;
                        eng_mod  <= 1'b0;
                    end else if (cmd_wr && wdata[CB_HOLD]) begin
                        st_q     <= ST_HOLD;
                        busy     <= '0;
                        eng_hold <= 1'b1;
                        cmd_word[CB_HOLD] <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cmd_wr && !wdata[CB_HOLD]) begin
                        st_q     <= ST_RUN;
                        busy     <= '1;
                        eng_hold <= 1'b0;
                        cmd_word[CB_HOLD] <= 1'b0;
                    end
                end
                default: begin
                    st_q     <= ST_IDLE;
                    lock     <= 1'b0;
                    cmd_word <= '0;
                end
            endcase
        end
    end

    // Present the active operation code to the engine.
    always_comb eng_op = op_q;
endmodule

// File: rtl/flash_wr_seq.sv
// Top of the flash write-control sequencer: register file, sequencer and bank gate.
// Assumes a single-cycle register bus with combinational read data.
module flash_wr_seq
    import fwc_pkg::*;
#(
    parameter int unsigned N_BANK   = 2,
    parameter int unsigned AW       = 20,
    parameter logic [AW-1:0] WIN_LO = 20'h0EDFB0,
    parameter logic [AW-1:0] WIN_HI = 20'h0EDFBF,
    parameter logic [15:0] BAD_WORD = 16'hFFFF,
    localparam int unsigned BSW = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_idx,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_trap,
    input  logic              bank_rd,
    input  logic              bank_wr,
    input  logic [BSW-1:0]    bank_sel,
    output logic              bank_trap,
    output logic              bank_wr_en,
    output logic              eng_start,
    output logic [1:0]        eng_op,
    output logic              eng_mod,
    output logic              eng_hold,
    input  logic              eng_done,
    output logic              stat_lock,
    output logic [N_BANK-1:0] stat_busy
);
    logic [DW-1:0] cmd_word;
    logic [AW-1:0] tgt_addr;
    logic          err_set;
    logic          prot_upd;
    logic          cmd_wr;

    // Command register writes go to the sequencer.
    always_comb cmd_wr = bus_wr && (bus_idx == IDX_CMD);

    fwc_seq #(
        .N_BANK(N_BANK), .AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(bus_wdata),
        .tgt_addr(tgt_addr), .eng_done(eng_done), .lock(stat_lock),
        .busy(stat_busy), .cmd_word(cmd_word), .eng_start(eng_start),
        .eng_op(eng_op), .eng_mod(eng_mod), .eng_hold(eng_hold),
        .err_set(err_set), .prot_upd(prot_upd)
    );

    fwc_regs #(
        .N_BANK(N_BANK), .AW(AW), .BAD_WORD(BAD_WORD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_trap(bus_trap), .lock(stat_lock), .busy(stat_busy),
        .cmd_word(cmd_word), .err_set(err_set), .prot_upd(prot_upd),
        .tgt_addr(tgt_addr)
    );

    fwc_bank_gate #(
        .N_BANK(N_BANK)
    ) u_gate (
        .busy(stat_busy), .bank_rd(bank_rd), .bank_wr(bank_wr),
        .bank_sel(bank_sel), .bank_trap(bank_trap), .bank_wr_en(bank_wr_en)
    );
endmodule

// File: rtl/fwc_chk.sv
// Protocol checker for flash_wr_seq, attached with bind. Assumes only port-level
// visibility of the top module.
module fwc_chk #(
    parameter int unsigned N_BANK = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock,
    input logic [N_BANK-1:0] busy,
    input logic              eng_start,
    input logic              eng_done,
    input logic              bus_rd,
    input logic [2:0]        bus_idx,
    input logic              bus_trap,
    input logic              bank_rd,
    input logic              bank_trap
);
    // R2
    start_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (lock && (busy == '1)));

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R6
    busy_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy != '0) |-> lock);

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && (busy != '0)) |=> (!lock && (busy == '0)));

    // R8
    reject_short_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock) && (busy == '0)) |=> !lock);

    // R3
    bus_trap_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_trap |-> (lock && bus_rd && (bus_idx != 3'd0)));

    // R5
    bank_trap_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_trap |-> (bank_rd && lock));
endmodule

bind flash_wr_seq fwc_chk #(.N_BANK(N_BANK)) u_fwc_chk (
    .clk(clk), .rst_n(rst_n), .lock(stat_lock), .busy(stat_busy),
    .eng_start(eng_start), .eng_done(eng_done), .bus_rd(bus_rd),
    .bus_idx(bus_idx), .bus_trap(bus_trap), .bank_rd(bank_rd),
    .bank_trap(bank_trap)
);

// File: tb/test_flash_wr_seq.sv
module test_flash_wr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ENG_LAT    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_idx = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_trap;
    logic        bank_rd = 1'b0, bank_wr = 1'b0;
    logic [0:0]  bank_sel = '0;
    logic        bank_trap, bank_wr_en;
    logic        eng_start, eng_mod, eng_hold;
    logic [1:0]  eng_op;
    logic        eng_done = 1'b0;
    logic        stat_lock;
    logic [1:0]  stat_busy;

    int n_run = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    flash_wr_seq i_flash_wr_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_trap(bus_trap), .bank_rd(bank_rd), .bank_wr(bank_wr),
        .bank_sel(bank_sel), .bank_trap(bank_trap), .bank_wr_en(bank_wr_en),
        .eng_start(eng_start), .eng_op(eng_op), .eng_mod(eng_mod),
        .eng_hold(eng_hold), .eng_done(eng_done), .stat_lock(stat_lock),
        .stat_busy(stat_busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference model: mode 0 idle, 1 running, 2 held, 3 rejected.
    int          m_mode = 0;
    bit          m_lock = 0, m_start = 0, m_mod = 0, m_hold = 0;
    bit [1:0]    m_busy = 0;
    int          m_op = 0;
    bit [15:0]   m_data = 0, m_alo = 0;
    bit [3:0]    m_ahi = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_lock = 0; m_start = 0; m_mod = 0; m_hold = 0;
            m_busy = 0; m_op = 0; m_data = 0; m_alo = 0; m_ahi = 0;
        end else begin
            int cnt;
            int addr;
            bit ok;
            m_start = 0;
            case (m_mode)
                0: begin
                    if (bus_wr && bus_idx == 3'd1 && bus_wdata[15]) begin
                        cnt  = int'(bus_wdata[13]) + int'(bus_wdata[12]) + int'(bus_wdata[11]);
                        addr = {m_ahi, m_alo};
                        ok   = (cnt == 1) && (!bus_wdata[11] || (addr >= 'h0EDFB0 && addr <= 'h0EDFBF));
                        m_lock = 1;
                        if (ok) begin
                            m_mode = 1; m_busy = 2'b11; m_start = 1;
                            m_op = bus_wdata[13] ? 1 : (bus_wdata[12] ? 2 : 3);
                            m_mod = bus_wdata[8];
                        end else begin
                            m_mode = 3;
                        end
                    end else if (bus_wr) begin
                        if (bus_idx == 3'd2) m_data = bus_wdata;
                        if (bus_idx == 3'd3) m_alo = bus_wdata;
                        if (bus_idx == 3'd4) m_ahi = bus_wdata[3:0];
                    end
                end
                1: begin
                    if (eng_done) begin
                        m_mode = 0; m_lock = 0; m_busy = 0; m_op = 0; m_mod = 0;
                    end else if (bus_wr && bus_idx == 3'd1 && bus_wdata[14]) begin
                        m_mode = 2; m_busy = 0; m_hold = 1;
                    end
                end
                2: begin
                    if (bus_wr && bus_idx == 3'd1 && !bus_wdata[14]) begin
                        m_mode = 1; m_busy = 2'b11; m_hold = 0;
                    end
                end
                default: begin
                    m_mode = 0; m_lock = 0;
                end
            endcase
        end
    end

    // Every-cycle comparison of the sequencer outputs with the model (R2 R6 R7 R8).
    always @(negedge clk) begin
        if (cmp_on) begin
            n_run++;
            if (stat_lock !== m_lock || stat_busy !== m_busy || eng_start !== m_start ||
                eng_op !== 2'(m_op) || eng_mod !== m_mod || eng_hold !== m_hold) begin
                n_fail++;
                $display("FAIL R2/R6/R7/R8 model compare: lock=%0b busy=%0b start=%0b op=%0d mod=%0b hold=%0b expected lock=%0b busy=%0b start=%0b op=%0d mod=%0b hold=%0b",
                    stat_lock, stat_busy, eng_start, eng_op, eng_mod, eng_hold,
                    m_lock, m_busy, m_start, m_op, m_mod, m_hold);
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] d);
        bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rchk(input logic [2:0] idx, input int exp, input bit exp_trap, input string tag);
        bus_rd = 1'b1; bus_idx = idx;
        #1;
        chk({tag, " rdata"}, int'(bus_rdata), exp);
        chk({tag, " trap"}, int'(bus_trap), int'(exp_trap));
        bus_rd = 1'b0;
    endtask

    task automatic bchk(input bit sel, input bit exp_trap, input string tag);
        bank_sel = sel; bank_rd = 1'b1;
        #1;
        chk({tag, " bank read trap"}, int'(bank_trap), int'(exp_trap));
        bank_rd = 1'b0; bank_wr = 1'b1;
        #1;
        chk({tag, " bank write pass"}, int'(bank_wr_en), int'(!exp_trap));
        bank_wr = 1'b0;
    endtask

    task automatic done_pulse();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic run_to_done();
        repeat (ENG_LAT - 1) @(negedge clk);
        done_pulse();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // R1: reset values
        rchk(3'd0, 0, 0, "R1 status");
        rchk(3'd1, 0, 0, "R1 command");
        rchk(3'd5, 0, 0, "R1 error");
        rchk(3'd6, 'hFFFF, 0, "R1 protection");
        chk("R1 start idle", int'(eng_start), 0);

        // Load data and address while unlocked
        wr(3'd2, 16'h1234);
        wr(3'd3, 16'h0100);
        wr(3'd4, 16'h0002);
        rchk(3'd2, 'h1234, 0, "R3 unlocked data");
        bchk(1'b0, 1'b0, "R5 idle bank0");

        // R2: program on primary module
        wr(3'd1, 16'hA100);
        chk("R2 start pulse", int'(eng_start), 1);
        chk("R2 op program", int'(eng_op), 1);
        chk("R2 module primary", int'(eng_mod), 1);
        rchk(3'd0, 7, 0, "R3 status while locked");
        rchk(3'd2, 'hFFFF, 1, "R3 data locked");
        rchk(3'd6, 'hFFFF, 1, "R3 protection locked");
        // R4: locked writes ignored
        wr(3'd2, 16'h5555);
        wr(3'd5, 16'h0001);
        bchk(1'b0, 1'b1, "R5 busy bank0");
        bchk(1'b1, 1'b1, "R5 busy bank1");

        // R6: hold, done ignored, resume
        wr(3'd1, 16'h4000);
        rchk(3'd0, 1, 0, "R6 held status");
        chk("R6 hold out", int'(eng_hold), 1);
        bchk(1'b1, 1'b0, "R6 held bank1 free");
        done_pulse();
        chk("R6 done ignored in hold", int'(stat_lock), 1);
        wr(3'd1, 16'h0000);
        rchk(3'd0, 7, 0, "R6 resumed status");
        chk("R6 hold released", int'(eng_hold), 0);

        // R7: completion
        run_to_done();
        rchk(3'd0, 0, 0, "R7 status after done");
        rchk(3'd1, 0, 0, "R7 command cleared");
        rchk(3'd2, 'h1234, 0, "R4 data kept");
        rchk(3'd5, 0, 0, "R4 error kept");

        // R2: erase on secondary module
        wr(3'd1, 16'h9000);
        chk("R2 op erase", int'(eng_op), 2);
        chk("R2 module secondary", int'(eng_mod), 0);
        run_to_done();
        rchk(3'd0, 0, 0, "R7 erase done");

        // R8: protection-set just below and just above the window
        wr(3'd3, 16'hDFAF);
        wr(3'd4, 16'h000E);
        wr(3'd1, 16'h8800);
        chk("R8 lock on reject", int'(stat_lock), 1);
        chk("R8 no busy", int'(stat_busy), 0);
        chk("R8 no start", int'(eng_start), 0);
        @(negedge clk);
        chk("R8 lock one cycle", int'(stat_lock), 0);
        rchk(3'd5, 1, 0, "R8 error set low side");
        wr(3'd5, 16'h0000);
        wr(3'd3, 16'hDFC0);
        wr(3'd1, 16'h8800);
        @(negedge clk);
        rchk(3'd5, 1, 0, "R8 error set high side");
        wr(3'd5, 16'h0000);

        // R9: accepted at both window edges, bits only cleared
        wr(3'd2, 16'hF0F3);
        wr(3'd3, 16'hDFB0);
        wr(3'd1, 16'h8800);
        chk("R9 op protect", int'(eng_op), 3);
        run_to_done();
        rchk(3'd6, 'hF0F3, 0, "R9 protect low edge");
        wr(3'd2, 16'h0FFF);
        wr(3'd3, 16'hDFBF);
        wr(3'd1, 16'h8800);
        run_to_done();
        rchk(3'd6, 'h00F3, 0, "R9 protect high edge");
        rchk(3'd5, 0, 0, "R9 no error");

        // R10: ambiguous and empty commands rejected
        wr(3'd1, 16'hB000);
        chk("R10 two ops no busy", int'(stat_busy), 0);
        @(negedge clk);
        rchk(3'd5, 1, 0, "R10 two ops error");
        wr(3'd5, 16'h0000);
        wr(3'd1, 16'h8000);
        chk("R10 no op no start", int'(eng_start), 0);
        @(negedge clk);
        rchk(3'd5, 1, 0, "R10 no op error");

        repeat (2) @(negedge clk);
        summary();
    end
endmodule